// File: doc/BRIEF.md
# 16 KB Granule Translation Table Walker

The walker turns a 48-bit virtual address into a physical address by reading up to four 64-bit descriptors from a table hierarchy laid out for a 16 KB translation granule. A caller hands it a virtual address, the base of the first table and a stage-2 flag. The walker then fetches one descriptor per level over a request/response memory port, decodes it, and either follows a table pointer down or stops.

A walk ends in one of two ways. A valid leaf gives a physical address, a page-size mask and a write-permission flag. An invalid descriptor gives a translation fault and the level at which it was found. Either way, `done` pulses for one cycle, and the results stay on the outputs until the next walk is accepted.

Control is one state machine with four states. S_IDLE waits for a start. S_REQ presents a descriptor read. S_RSP waits for the returned descriptor. S_FIN raises `done`. The transitions are:

- start: S_IDLE to S_REQ, on `start_valid`.
- issue: S_REQ to S_RSP, on `mem_req_ready`.
- descend: S_RSP to S_REQ, on a valid table descriptor.
- finish: S_RSP to S_FIN, on a leaf or an invalid descriptor.
- release: S_FIN to S_IDLE, unconditionally.

Top module: `ptw16k_walker`

## Requirements
- R1: `start_ready` is high exactly in the idle state. A `start_valid` seen while a walk is in progress has no effect on that walk's results.
- R2: Every walk begins at level 0. The read address at each level is the current table base plus eight times that level's index field. The index fields are VA[47] at level 0, VA[46:36] at level 1, VA[35:25] at level 2 and VA[24:14] at level 3.
- R3: At levels 0 to 2, a descriptor is valid when bit 0 is 1. At level 3, bits 0 and 1 must both be 1.
- R4: Level 0 and level 1 descriptors are always tables. A valid level 2 descriptor is a block leaf when bit 1 is 0, and a table otherwise. Every valid level 3 descriptor is a page leaf. A table's next base is descriptor bits [47:12], with bits [11:0] set to zero.
- R5: The leaf output address is descriptor bits [47:25] at level 2 and bits [47:14] at level 3. `out_pa` takes the bits above the page offset from the leaf output address and the bits below it from the virtual address.
- R6: Descriptor bit 52 is the contiguous hint. The page offset width is 25 bits at level 2, or 30 bits with the hint. It is 14 bits at level 3, or 21 bits with the hint. `out_mask` has ones above the offset and zeros within it.
- R7: With `start_s2` set, a leaf is writable only when bits [7:6] are both 1. With `start_s2` clear, a leaf is writable only when bit 7 is 0.
- R8: An invalid descriptor stops the walk. It sets `fault`, reports the level in `fault_level` (0 to 3), and drives `out_pa`, `out_mask` and `out_writable` to zero.
- R9: At most one read is outstanding at a time. Once a request is raised, it and its address stay unchanged until `mem_req_ready` is seen. A walk that stops at level L makes exactly L+1 reads.
- R10: `done` is high for exactly one cycle per accepted walk, whether the walk succeeded or faulted.
- R11: After reset, the walker is idle, `done` and `mem_req_valid` are low, and `fault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Walk request |
| start_ready | output | 1 | High when a walk can be accepted |
| start_va | input | 48 | Virtual address to translate |
| start_base | input | 48 | Byte address of the level-0 table |
| start_s2 | input | 1 | Select stage-2 permission decoding |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor returned |
| mem_rsp_data | input | 64 | Returned descriptor |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Walk ended on an invalid descriptor |
| fault_level | output | 2 | Level of the faulting descriptor |
| out_pa | output | 48 | Translated physical address |
| out_mask | output | 48 | Ones above the page offset |
| out_writable | output | 1 | Leaf grants write access |

## Verification
A wrong index field or a stale table base makes the walker read the wrong address. The bench memory returns zero for any address it was not loaded with, so the error turns into a fault at that level, visible when `done` rises a few cycles later. A level counter that is off by one shows up in the same pulse, either as a wrong `fault_level` or as a wrong read count. A wrong offset width or permission decode shows up directly in `out_mask`, `out_pa` or `out_writable` on that same pulse. A stuck state shows up as a missing `done`, or as `done` staying high in the next cycle.

// File: rtl/ptw16k_pkg.sv
package ptw16k_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_RSP  = 2'd2,
        S_FIN  = 2'd3
    } walk_state_t;

    localparam int GRAN_BITS  = 14;
    localparam int IDX_W      = GRAN_BITS - 3;
    localparam int TBL_ALIGN  = 12;
    localparam int CONTIG_BIT = 52;
    localparam int OFS_W      = 6;
    localparam int L2_BLK     = GRAN_BITS + IDX_W;
    localparam int L2_CONTIG  = 30;
    localparam int L3_CONTIG  = 21;
endpackage

// File: rtl/ptw16k_addr_gen.sv
module ptw16k_addr_gen
    import ptw16k_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic [VA_W-1:0] va,
    input  logic [1:0]      level,
    input  logic [VA_W-1:0] base,
    output logic [VA_W-1:0] addr
);
    localparam int L3_LO = GRAN_BITS;
    localparam int L2_LO = L3_LO + IDX_W;
    localparam int L1_LO = L2_LO + IDX_W;
    localparam int L0_LO = L1_LO + IDX_W;
    localparam int PAD_W = VA_W - IDX_W - 3;

    logic [IDX_W-1:0] idx;
    logic             unused_va_lo;

    always_comb begin
        unique case (level)
            2'd0:    idx = {{(IDX_W-1){1'b0}}, va[L0_LO]};
            2'd1:    idx = va[L1_LO +: IDX_W];
            2'd2:    idx = va[L2_LO +: IDX_W];
            default: idx = va[L3_LO +: IDX_W];
        endcase
    end

    assign addr         = base + {{PAD_W{1'b0}}, idx, 3'b000};
    assign unused_va_lo = ^va[L3_LO-1:0];
endmodule

// File: rtl/ptw16k_desc_decode.sv
module ptw16k_desc_decode
    import ptw16k_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int DESC_W = 64
) (
    input  logic [DESC_W-1:0] desc,
    input  logic [1:0]        level,
    input  logic              stage2,
    input  logic [VA_W-1:0]   va,
    output logic              d_valid,
    output logic              d_leaf,
    output logic [VA_W-1:0]   next_base,
    output logic [VA_W-1:0]   pa,
    output logic [VA_W-1:0]   mask,
    output logic              writable
);
    localparam logic [VA_W-1:0] ONES = '1;

    logic              is_l3;
    logic              contig;
    logic [OFS_W-1:0]  ofs;
    logic [VA_W-1:0]   oa;
    logic              unused_bits;

    assign is_l3   = (level == 2'd3);
    assign contig  = desc[CONTIG_BIT];
    assign d_valid = is_l3 ? (desc[0] & desc[1]) : desc[0];
    assign d_leaf  = is_l3 | ((level == 2'd2) & ~desc[1]);

    assign next_base = {desc[VA_W-1:TBL_ALIGN], {TBL_ALIGN{1'b0}}};

    always_comb begin
        if (is_l3) begin
            ofs = contig ? OFS_W'(L3_CONTIG) : OFS_W'(GRAN_BITS);
            oa  = {desc[VA_W-1:GRAN_BITS], {GRAN_BITS{1'b0}}};
        end else begin
            ofs = contig ? OFS_W'(L2_CONTIG) : OFS_W'(L2_BLK);
            oa  = {desc[VA_W-1:L2_BLK], {L2_BLK{1'b0}}};
        end
    end

    assign mask     = ONES << ofs;
    assign pa       = (oa & mask) | (va & ~mask);
    assign writable = stage2 ? (desc[7] & desc[6]) : ~desc[7];

    assign unused_bits = ^{desc[DESC_W-1:CONTIG_BIT+1], desc[CONTIG_BIT-1:VA_W],
                           desc[TBL_ALIGN-1:8], desc[5:2]};
endmodule

// File: rtl/ptw16k_walker.sv
module ptw16k_walker
    import ptw16k_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int DESC_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [VA_W-1:0]   start_va,
    input  logic [VA_W-1:0]   start_base,
    input  logic              start_s2,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_level,
    output logic [VA_W-1:0]   out_pa,
    output logic [VA_W-1:0]   out_mask,
    output logic              out_writable
);
    walk_state_t     st, st_nx;
    logic [1:0]      lvl;
    logic [VA_W-1:0] va_q, base_q, req_addr;
    logic            s2_q;
    logic            d_valid, d_leaf, d_wr;
    logic [VA_W-1:0] d_next, d_pa, d_mask;

    ptw16k_addr_gen #(.VA_W(VA_W)) u_addr (
        .va(va_q), .level(lvl), .base(base_q), .addr(req_addr)
    );

    ptw16k_desc_decode #(.VA_W(VA_W), .DESC_W(DESC_W)) u_dec (
        .desc(mem_rsp_data), .level(lvl), .stage2(s2_q), .va(va_q),
        .d_valid(d_valid), .d_leaf(d_leaf), .next_base(d_next),
        .pa(d_pa), .mask(d_mask), .writable(d_wr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (start_valid)   st_nx = S_REQ;
            S_REQ:  if (mem_req_ready) st_nx = S_RSP;
            S_RSP:  if (mem_rsp_valid) st_nx = (!d_valid || d_leaf) ? S_FIN : S_REQ;
            S_FIN:                     st_nx = S_IDLE;
            default:                   st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= '0; va_q <= '0; base_q <= '0; s2_q <= 1'b0;
            fault <= 1'b0; fault_level <= '0;
            out_pa <= '0; out_mask <= '0; out_writable <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (start_valid) begin
                    lvl <= '0; va_q <= start_va; base_q <= start_base; s2_q <= start_s2;
                    fault <= 1'b0; fault_level <= '0;
                    out_pa <= '0; out_mask <= '0; out_writable <= 1'b0;
                end
                S_RSP: if (mem_rsp_valid) begin
                    if (!d_valid) begin
                        fault <= 1'b1; fault_level <= lvl;
                        out_pa <= '0; out_mask <= '0; out_writable <= 1'b0;
                    end else if (d_leaf) begin
                        out_pa <= d_pa; out_mask <= d_mask; out_writable <= d_wr;
                    end else begin
                        base_q <= d_next;
                        lvl    <= lvl + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign start_ready   = (st == S_IDLE);
    assign mem_req_valid = (st == S_REQ);
    assign mem_req_addr  = req_addr;
    assign done          = (st == S_FIN);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> !mem_req_valid && !done);
    assert_fault_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> !out_writable && out_mask == '0);
    assert_mask_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> out_mask[13:0] == '0 && out_mask[VA_W-1]);
endmodule

// File: tb/test_ptw16k_walker.sv
module test_ptw16k_walker;
    localparam int CLK_P = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [47:0] va;
        logic [47:0] base;
        logic        s2;
        logic [63:0] d0, d1, d2, d3;
        logic        f;
        logic [1:0]  lv;
        logic [47:0] pa;
        logic [5:0]  sh;
        logic        wr;
    } vec_t;

    localparam logic [47:0] VA_A = 48'h8123_4567_89AB;
    localparam logic [47:0] VA_B = 48'h0123_4567_89AB;
    localparam logic [47:0] BS   = 48'h0000_0001_0000;
    localparam logic [63:0] T0 = 64'h0000_0000_0002_0003;
    localparam logic [63:0] T1 = 64'h0000_0000_0003_0003;
    localparam logic [63:0] T2 = 64'h0000_0000_0004_0003;

    localparam vec_t VECS [NV] = '{
        '{VA_A, BS, 1'b0, T0, T1, T2, 64'h0000_0012_3456_C003, 1'b0, 2'd3, 48'h0012_3456_C9AB, 6'd14, 1'b1},
        '{VA_A, BS, 1'b0, T0, T1, T2, 64'h0010_0012_3456_C083, 1'b0, 2'd3, 48'h0012_3447_89AB, 6'd21, 1'b0},
        '{VA_B, BS, 1'b0, T0, T1, 64'h0000_0000_5E00_0001, 64'h0, 1'b0, 2'd2, 48'h0000_5F67_89AB, 6'd25, 1'b1},
        '{VA_B, BS, 1'b1, T0, T1, 64'h0000_0000_5E00_00C1, 64'h0, 1'b0, 2'd2, 48'h0000_5F67_89AB, 6'd25, 1'b1},
        '{VA_A, BS, 1'b1, T0, T1, 64'h0000_0000_5E00_0041, 64'h0, 1'b0, 2'd2, 48'h0000_5F67_89AB, 6'd25, 1'b0},
        '{VA_A, BS, 1'b0, T0, T1, 64'h0010_0000_5E00_0001, 64'h0, 1'b0, 2'd2, 48'h0000_4567_89AB, 6'd30, 1'b1},
        '{VA_A, BS, 1'b0, 64'h0, T1, T2, 64'h0, 1'b1, 2'd0, 48'h0, 6'd0, 1'b0},
        '{VA_B, BS, 1'b0, T0, 64'h0000_0000_0003_0002, T2, 64'h0, 1'b1, 2'd1, 48'h0, 6'd0, 1'b0},
        '{VA_A, BS, 1'b0, T0, T1, 64'h0000_0000_0004_0000, 64'h0, 1'b1, 2'd2, 48'h0, 6'd0, 1'b0},
        '{VA_A, BS, 1'b0, T0, T1, T2, 64'h0000_0012_3456_C001, 1'b1, 2'd3, 48'h0, 6'd0, 1'b0},
        '{VA_A, BS, 1'b1, T0, T1, T2, 64'h0000_0012_3456_C0C3, 1'b0, 2'd3, 48'h0012_3456_C9AB, 6'd14, 1'b1},
        '{VA_A, BS, 1'b1, T0, T1, T2, 64'h0000_0012_3456_C083, 1'b0, 2'd3, 48'h0012_3456_C9AB, 6'd14, 1'b0}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start_valid = 1'b0, start_s2 = 1'b0;
    logic [47:0] start_va = '0, start_base = '0;
    logic        start_ready, mem_req_valid, done, fault, out_writable;
    logic        mem_req_ready = 1'b1, mem_rsp_valid = 1'b0, stall_en = 1'b0;
    logic [47:0] mem_req_addr, out_pa, out_mask;
    logic [63:0] mem_rsp_data = '0;
    logic [1:0]  fault_level;

    logic [47:0] m_addr [4];
    logic [63:0] m_data [4];
    int          rd_cnt = 0;
    int          n_run = 0, n_fail = 0;

    ptw16k_walker i_ptw16k_walker (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .start_va(start_va), .start_base(start_base), .start_s2(start_s2),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
        .fault(fault), .fault_level(fault_level), .out_pa(out_pa), .out_mask(out_mask),
        .out_writable(out_writable)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [63:0] lookup(input logic [47:0] a);
        logic [63:0] r = '0;
        for (int k = 0; k < 4; k++) if (m_addr[k] == a) r = m_data[k];
        return r;
    endfunction

    always @(posedge clk) begin
        mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= lookup(mem_req_addr);
            rd_cnt        <= rd_cnt + 1;
        end else begin
            mem_rsp_valid <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R2/R4: place each descriptor where the level's index field selects it
    task automatic load(input vec_t v);
        m_addr[0] = v.base + {44'd0, v.va[47], 3'b000};  m_data[0] = v.d0;
        m_addr[1] = {v.d0[47:12], 12'd0} + {34'd0, v.va[46:36], 3'b000}; m_data[1] = v.d1;
        m_addr[2] = {v.d1[47:12], 12'd0} + {34'd0, v.va[35:25], 3'b000}; m_data[2] = v.d2;
        m_addr[3] = {v.d2[47:12], 12'd0} + {34'd0, v.va[24:14], 3'b000}; m_data[3] = v.d3;
    endtask

    task automatic walk(input vec_t v, input bit poke_busy);
        int rd0, wd;
        logic [47:0] em;
        load(v);
        rd0 = rd_cnt;
        @(negedge clk);
        start_valid = 1'b1; start_va = v.va; start_base = v.base; start_s2 = v.s2;
        @(negedge clk);
        start_valid = 1'b0;
        check("R1 busy after accept", {63'd0, start_ready}, 64'd0);
        if (poke_busy) begin
            start_valid = 1'b1; start_va = 48'h0; start_base = 48'hFFFF_0000_0000; start_s2 = ~v.s2;
            @(negedge clk);
            @(negedge clk);
            start_valid = 1'b0;
        end
        wd = 0;
        while (!done && wd < 200) begin @(negedge clk); wd++; end
        check("R10 done seen", {63'd0, done}, 64'd1);
        em = v.f ? 48'd0 : (48'hFFFF_FFFF_FFFF << v.sh);
        check("R8 fault", {63'd0, fault}, {63'd0, v.f});
        if (v.f) check("R8 fault_level", {62'd0, fault_level}, {62'd0, v.lv});
        check("R5 out_pa", {16'd0, out_pa}, {16'd0, v.pa});
        check("R6 out_mask", {16'd0, out_mask}, {16'd0, em});
        check("R7 out_writable", {63'd0, out_writable}, {63'd0, v.wr});
        check("R9 read count", 64'(rd_cnt - rd0), 64'(v.lv) + 64'd1);
        @(negedge clk);
        check("R10 done one cycle", {63'd0, done}, 64'd0);
        check("R1 ready after walk", {63'd0, start_ready}, 64'd1);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin m_addr[k] = '1; m_data[k] = '0; end
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 ready in reset", {63'd0, start_ready}, 64'd1);
        check("R11 done low", {63'd0, done}, 64'd0);
        check("R11 no request", {63'd0, mem_req_valid}, 64'd0);
        check("R11 no fault", {63'd0, fault}, 64'd0);
        rst_n = 1'b1;
        // R2 R3 R4 R5 R6 R7 R8: vector table
        for (int i = 0; i < NV; i++) walk(VECS[i], 1'b0);
        // R1: start pulses while busy are ignored
        walk(VECS[0], 1'b1);
        walk(VECS[9], 1'b1);
        // R9: request held across stalls
        stall_en = 1'b1;
        walk(VECS[0], 1'b0);
        walk(VECS[5], 1'b0);
        walk(VECS[7], 1'b0);
        stall_en = 1'b0;
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule